// File: doc/BRIEF.md
# Link Procedure Control Capability

This block is a vendor-specific capability that sits inside an emulated PCI configuration space. A host uses it to start link-management procedures on a serial-link PHY, such as reset, impedance calibration, DC calibration and training, and then polls until they finish. The block decodes configuration dword reads and writes that fall within its four-dword window. It holds the control, status and link-number registers and passes each accepted procedure to a backend through a start/done/result handshake.

The block works as a small mailbox. A write to the control dword names a procedure. Some numbers finish at once without the backend: a no-op, numbers that are reserved or unsupported, an abort while idle, and a repeat of the one-time impedance calibration. Every other number starts the backend, and the status shows the run as in progress. A write that arrives while a run is active aborts that run. The backend is told to stop, the abort is reported, and if the new number is non-zero it then starts. The impedance calibration procedure reaches the backend at most once per reset.

Top module: `lnk_proc_cap`

## Requirements
- R1: The dword at `CAP_BASE` reads as the header: capability ID 0x09 in bits 7:0, `NEXT_PTR` in bits 15:8, length 16 (bytes) in bits 23:16, and zero in bits 31:24.
- R2: The dword at `CAP_BASE+3` reads as `LINK_NUM` in bits 7:0 with every other bit zero. Addresses outside `CAP_BASE` to `CAP_BASE+3` read as zero.
- R3: After reset, the status dword (`CAP_BASE+1`) and the control dword (`CAP_BASE+2`) read zero, and `be_start` and `be_cancel` are low.
- R4: Writing a number from 4 to 12 while idle starts it. The status then reads in-progress (bit 31 set, bit 30 clear, code 0), `be_start` is high and `be_proc` carries the number. When `be_done` is seen, `be_start` drops and the status reads complete (bit 30 set, bit 31 clear) with the backend result as the code.
- R5: The backend result is reported as the completion code in status bits 3:0: 0 means success, 1 a transient failure and 2 a permanent failure.
- R6: Writing 1 (no-op) while idle completes by the next cycle with status 0x4000_0000, without raising `be_start`.
- R7: Writing 2, 3 or any number above 12 while idle completes by the next cycle with status 0x4000_0004 (code 4, unsupported), without raising `be_start`.
- R8: Writing 0 while a run is active drops `be_start`, pulses `be_cancel` for exactly one cycle and gives status 0x4000_0003 (code 3, aborted). Writing 0 while idle also gives status 0x4000_0003.
- R9: Writing a non-zero number while a run is active aborts the run as in R8. One cycle later the new number is dispatched as if written while idle.
- R10: Procedure 5 (impedance calibration) reaches the backend at most once per reset. A later request completes by the next cycle with status 0x4000_0000 and no `be_start`. Reset re-arms the procedure.
- R11: Writes to the header, status and link-number dwords have no effect.
- R12: The control dword reads the number of the procedure running now or, when idle, the last number accepted. An abort keeps the aborted number until a new number is dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | ADDR_W | Configuration dword address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| be_start | output | 1 | Backend run request, held until done or abort |
| be_proc | output | 4 | Procedure number for the backend |
| be_cancel | output | 1 | One-cycle abort pulse to the backend |
| be_done | input | 1 | Backend completion pulse |
| be_result | input | 2 | Backend result (0 ok, 1 transient, 2 permanent), valid with `be_done` |

## Verification
The control dword is driven with every kind of number: a no-op, numbers that are reserved, beyond the range or wide, PHY numbers that go to the backend with each result code, and zero both while idle and during a run. These patterns separate the immediate completion paths from the backend path and show whether the code comes from the backend or from the block itself. Aborts are tried with zero and with a new number, which shows whether the pending number is dispatched after the cancel. Impedance calibration is requested twice, then once more after a reset, which shows whether the one-time guard works and whether reset re-arms it.

// File: rtl/lpc_pkg.sv
// Shared types for the link procedure control capability.
// Assumes procedure numbers are written as full 32-bit dwords.
package lpc_pkg;

    localparam logic [7:0] CAP_ID     = 8'h09;
    localparam int         CAP_DWORDS = 4;
    localparam int         PROC_NUM_W = 4;
    localparam logic [31:0] PROC_ABORT = 32'd0;
    localparam logic [31:0] PROC_NOP   = 32'd1;
    localparam logic [31:0] PROC_ZCAL  = 32'd5;
    localparam logic [31:0] PROC_MAX   = 32'd12;

    typedef enum logic [3:0] {
        CC_OK          = 4'd0,
        CC_TRANSIENT   = 4'd1,
        CC_PERMANENT   = 4'd2,
        CC_ABORTED     = 4'd3,
        CC_UNSUPPORTED = 4'd4
    } cc_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RUN,
        SQ_ABORT
    } sq_e;

    typedef enum logic [1:0] {
        K_ABORT,
        K_INSTANT,
        K_UNSUP,
        K_BACKEND
    } kind_e;

    // Sorts a requested number into the path that serves it
    function automatic kind_e classify(input logic [31:0] num, input logic zcal_used);
        if (num == PROC_ABORT)                  return K_ABORT;
        else if (num == PROC_NOP)               return K_INSTANT;
        else if (num < 32'd4 || num > PROC_MAX) return K_UNSUP;
        else if (num == PROC_ZCAL && zcal_used) return K_INSTANT;
        else                                    return K_BACKEND;
    endfunction

endpackage

// File: rtl/lpc_decode.sv
// Address decode and read mux for the four-dword capability window.
// Assumes cfg_addr is a dword address and that CAP_BASE+3 fits in ADDR_W.
module lpc_decode #(
    parameter int ADDR_W   = 10,
    parameter int CAP_BASE = 16
) (
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr_en,
    input  logic [31:0]       hdr_word,
    input  logic [31:0]       stat_word,
    input  logic [31:0]       ctrl_word,
    input  logic [31:0]       link_word,
    output logic [31:0]       rdata,
    output logic              ctrl_wr
);
    import lpc_pkg::*;

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CAP_BASE);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(CAP_BASE + CAP_DWORDS - 1);
    localparam int IDX_W = $clog2(CAP_DWORDS);

    logic [31:0]       words [CAP_DWORDS];
    logic              in_win;
    logic [ADDR_W-1:0] offset;
    logic [IDX_W-1:0]  idx;

    assign words[0] = hdr_word;
    assign words[1] = stat_word;
    assign words[2] = ctrl_word;
    assign words[3] = link_word;

    // Window hit and dword index inside the capability
    always_comb begin
        in_win = (cfg_addr >= BASE_A) && (cfg_addr <= LAST_A);
        offset = cfg_addr - BASE_A;
        idx    = offset[IDX_W-1:0];
    end

    // Read mux; outside the window the capability drives zero
    always_comb begin
        rdata = in_win ? words[idx] : 32'd0;
    end

    // Only the control dword accepts writes
    always_comb begin
        ctrl_wr = cfg_wr_en && in_win && (idx == IDX_W'(2));
    end

endmodule

// File: rtl/lpc_zcal_guard.sv
// One-time guard for the impedance calibration procedure.
// Assumes fire pulses in the cycle the procedure is handed to the backend.
module lpc_zcal_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic used
);
    // Arm on reset, latch once the procedure has been dispatched
    always_ff @(posedge clk) begin
        if (!rst_n)    used <= 1'b0;
        else if (fire) used <= 1'b1;
    end

endmodule

// File: rtl/lpc_sequencer.sv
// Procedure sequencer: dispatch, backend handshake, abort and completion codes.
// Assumes the backend returns results 0..2 and never raises done without start.
module lpc_sequencer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [31:0] wdata,
    input  logic        zcal_used,
    input  logic        be_done,
    input  logic [1:0]  be_result,
    output logic        busy,
    output logic        done,
    output logic [3:0]  code,
    output logic [31:0] cur_num,
    output logic        be_start,
    output logic [lpc_pkg::PROC_NUM_W-1:0] be_proc,
    output logic        be_cancel,
    output logic        zcal_fire
);
    import lpc_pkg::*;

    sq_e         state;
    logic [31:0] pend_num;
    logic        disp_req;
    logic [31:0] disp_num;
    kind_e       kind;

    // Pick the number to dispatch: a fresh write wins over a pending one
    always_comb begin
        disp_req  = (state == SQ_ABORT) || ((state == SQ_IDLE) && ctrl_wr);
        disp_num  = ctrl_wr ? wdata : pend_num;
        kind      = classify(disp_num, zcal_used);
        zcal_fire = disp_req && (kind == K_BACKEND) && (disp_num == PROC_ZCAL);
    end

    // Main sequencer state, status fields and backend handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            pend_num  <= 32'd0;
            busy      <= 1'b0;
            done      <= 1'b0;
            code      <= CC_OK;
            cur_num   <= 32'd0;
            be_start  <= 1'b0;
            be_proc   <= '0;
            be_cancel <= 1'b0;
        end else begin
            be_cancel <= 1'b0;
            case (state)
                SQ_RUN: begin
                    if (ctrl_wr) begin
                        be_start  <= 1'b0;
                        be_cancel <= 1'b1;
                        busy      <= 1'b0;
                        done      <= 1'b1;
                        code      <= CC_ABORTED;
                        pend_num  <= wdata;
                        state     <= (wdata != PROC_ABORT) ? SQ_ABORT : SQ_IDLE;
                    end else if (be_done) begin
                        be_start <= 1'b0;
                        busy     <= 1'b0;
                        done     <= 1'b1;
                        code     <= {2'b00, be_result};
                        state    <= SQ_IDLE;
                    end
                end
                default: begin
                    if (disp_req) begin
                        cur_num <= disp_num;
                        state   <= SQ_IDLE;
                        case (kind)
                            K_ABORT: begin
                                busy <= 1'b0;
                                done <= 1'b1;
                                code <= CC_ABORTED;
                            end
                            K_INSTANT: begin
                                busy <= 1'b0;
                                done <= 1'b1;
                                code <= CC_OK;
                            end
                            K_UNSUP: begin
                                busy <= 1'b0;
                                done <= 1'b1;
                                code <= CC_UNSUPPORTED;
                            end
                            default: begin
                                busy     <= 1'b1;
                                done     <= 1'b0;
                                code     <= CC_OK;
                                be_start <= 1'b1;
                                be_proc  <= disp_num[PROC_NUM_W-1:0];
                                state    <= SQ_RUN;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/lnk_proc_cap.sv
// Link procedure control capability: header, status, control and link-number
// dwords in a configuration window, driving a start/done/result backend.
// Assumes LINK_NUM is one of 0, 1, 4 or 5 and NEXT_PTR is set by the integrator.
module lnk_proc_cap #(
    parameter int         ADDR_W   = 10,
    parameter int         CAP_BASE = 16,
    parameter logic [7:0] NEXT_PTR = 8'h00,
    parameter int         LINK_NUM = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              be_start,
    output logic [3:0]        be_proc,
    output logic              be_cancel,
    input  logic              be_done,
    input  logic [1:0]        be_result
);
    import lpc_pkg::*;

    localparam logic [7:0] CAP_LEN_B = 8'(CAP_DWORDS * 4);

    logic        ctrl_wr;
    logic        zcal_used;
    logic        zcal_fire;
    logic        busy;
    logic        done;
    logic [3:0]  code;
    logic [31:0] cur_num;
    logic [31:0] hdr_word;
    logic [31:0] stat_word;
    logic [31:0] link_word;

    // Assemble the read-only and status dwords
    always_comb begin
        hdr_word  = {8'h00, CAP_LEN_B, NEXT_PTR, CAP_ID};
        stat_word = {busy, done, 26'd0, code};
        link_word = {24'd0, 8'(LINK_NUM)};
    end

    lpc_decode #(
        .ADDR_W   (ADDR_W),
        .CAP_BASE (CAP_BASE)
    ) u_decode (
        .cfg_addr  (cfg_addr),
        .cfg_wr_en (cfg_wr_en),
        .hdr_word  (hdr_word),
        .stat_word (stat_word),
        .ctrl_word (cur_num),
        .link_word (link_word),
        .rdata     (cfg_rdata),
        .ctrl_wr   (ctrl_wr)
    );

    lpc_zcal_guard u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (zcal_fire),
        .used  (zcal_used)
    );

    lpc_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wdata     (cfg_wdata),
        .zcal_used (zcal_used),
        .be_done   (be_done),
        .be_result (be_result),
        .busy      (busy),
        .done      (done),
        .code      (code),
        .cur_num   (cur_num),
        .be_start  (be_start),
        .be_proc   (be_proc),
        .be_cancel (be_cancel),
        .zcal_fire (zcal_fire)
    );

endmodule

// File: rtl/lpc_checker.sv
// Protocol checks on the backend handshake and the status fields.
// Assumes it is bound to lnk_proc_cap and sees its internal status flops.
module lpc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [3:0] code,
    input logic       be_start,
    input logic [3:0] be_proc,
    input logic       be_cancel,
    input logic       be_done
);
    logic zcal_seen;

    // Remember whether calibration has reached the backend since reset
    always_ff @(posedge clk) begin
        if (!rst_n)                             zcal_seen <= 1'b0;
        else if (be_start && be_proc == 4'd5)   zcal_seen <= 1'b1;
    end

    // R4
    start_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_start |-> busy);

    // R4
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R4
    done_drops_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (be_start && be_done) |=> !be_start);

    // R8
    cancel_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_cancel |=> !be_cancel);

    // R8
    cancel_reports_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        be_cancel |-> (done && code == 4'd3 && !be_start));

    // R10
    zcal_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(be_start) && be_proc == 4'd5) |-> !zcal_seen);

endmodule

bind lnk_proc_cap lpc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .code      (code),
    .be_start  (be_start),
    .be_proc   (be_proc),
    .be_cancel (be_cancel),
    .be_done   (be_done)
);

// File: tb/lnk_proc_cap_bench.sv
module lnk_proc_cap_bench;

    localparam int         ADDR_W   = 10;
    localparam int         CAP_BASE = 16;
    localparam logic [7:0] NEXT_PTR = 8'h50;
    localparam int         LINK_NUM = 5;
    localparam logic [9:0] A_HDR  = 10'd16;
    localparam logic [9:0] A_STAT = 10'd17;
    localparam logic [9:0] A_CTRL = 10'd18;
    localparam logic [9:0] A_LINK = 10'd19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr_en = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              be_start;
    logic [3:0]        be_proc;
    logic              be_cancel;
    logic              be_done = 1'b0;
    logic [1:0]        be_result = 2'd0;

    int        checks = 0;
    int        fails = 0;
    int        stub_lat = 4;
    logic [1:0] stub_res = 2'd0;
    int        stub_cnt = 0;
    int        zcal_runs = 0;
    logic      start_q = 1'b0;
    int        wd = 0;

    logic [31:0] exp_q[$];
    logic [31:0] obs_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    lnk_proc_cap #(
        .ADDR_W   (ADDR_W),
        .CAP_BASE (CAP_BASE),
        .NEXT_PTR (NEXT_PTR),
        .LINK_NUM (LINK_NUM)
    ) u_lnk_proc_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .be_start  (be_start),
        .be_proc   (be_proc),
        .be_cancel (be_cancel),
        .be_done   (be_done),
        .be_result (be_result)
    );

    // Backend stub: answers a held start after stub_lat cycles
    always @(posedge clk) begin
        be_done <= 1'b0;
        if (!be_start) stub_cnt <= 0;
        else if (!be_done) begin
            if (stub_cnt >= stub_lat) begin
                be_done   <= 1'b1;
                be_result <= stub_res;
                stub_cnt  <= 0;
            end else stub_cnt <= stub_cnt + 1;
        end
    end

    // Count calibration runs that reach the backend
    always @(posedge clk) begin
        start_q <= be_start;
        if (!rst_n) start_q <= 1'b0;
        else if (be_start && !start_q && be_proc == 4'd5) zcal_runs <= zcal_runs + 1;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Monitor: compares observed items against the expected queue
    always @(negedge clk) begin
        while (obs_q.size() > 0 && exp_q.size() > 0) begin
            logic [31:0] o;
            logic [31:0] e;
            string t;
            o = obs_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (o !== e) begin
                fails++;
                $display("FAIL %s: actual 0x%08h expected 0x%08h", t, o, e);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            summary();
        end
    end

    task automatic push(input string t, input logic [31:0] act, input logic [31:0] exp);
        tag_q.push_back(t);
        exp_q.push_back(exp);
        obs_q.push_back(act);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string t, input logic [9:0] a, input logic [31:0] exp);
        cfg_addr = a;
        #1;
        push(t, cfg_rdata, exp);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            cfg_addr = A_STAT;
            #1;
            if (cfg_rdata[30]) break;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R3 reset state
        rd_chk("R3 status after reset", A_STAT, 32'h0);
        rd_chk("R3 control after reset", A_CTRL, 32'h0);
        push("R3 be_start after reset", {31'd0, be_start}, 32'd0);
        push("R3 be_cancel after reset", {31'd0, be_cancel}, 32'd0);

        // R1 header, R2 link number and window edges
        rd_chk("R1 header", A_HDR, {8'h00, 8'h10, NEXT_PTR, 8'h09});
        rd_chk("R2 link number", A_LINK, 32'd5);
        rd_chk("R2 above window", 10'd20, 32'd0);
        rd_chk("R2 below window", 10'd15, 32'd0);

        // R6 no-op
        wr(A_CTRL, 32'd1);
        rd_chk("R6 nop status", A_STAT, 32'h4000_0000);
        push("R6 nop no start", {31'd0, be_start}, 32'd0);
        rd_chk("R12 nop control", A_CTRL, 32'd1);

        // R7 unsupported numbers
        wr(A_CTRL, 32'd2);
        rd_chk("R7 proc 2", A_STAT, 32'h4000_0004);
        wr(A_CTRL, 32'd3);
        rd_chk("R7 proc 3", A_STAT, 32'h4000_0004);
        push("R7 no start", {31'd0, be_start}, 32'd0);
        wr(A_CTRL, 32'd13);
        rd_chk("R7 proc 13", A_STAT, 32'h4000_0004);
        wr(A_CTRL, 32'h104);
        rd_chk("R7 wide proc", A_STAT, 32'h4000_0004);
        rd_chk("R12 wide control", A_CTRL, 32'h104);

        // R4 backend run with success
        stub_lat = 4; stub_res = 2'd0;
        wr(A_CTRL, 32'd4);
        rd_chk("R4 in progress", A_STAT, 32'h8000_0000);
        push("R4 start high", {31'd0, be_start}, 32'd1);
        push("R4 proc number", {28'd0, be_proc}, 32'd4);
        rd_chk("R12 running control", A_CTRL, 32'd4);
        wait_done();
        rd_chk("R4 complete ok", A_STAT, 32'h4000_0000);
        push("R4 start dropped", {31'd0, be_start}, 32'd0);
        rd_chk("R12 last completed", A_CTRL, 32'd4);

        // R5 result codes
        stub_res = 2'd1;
        wr(A_CTRL, 32'd6);
        wait_done();
        rd_chk("R5 transient", A_STAT, 32'h4000_0001);
        stub_res = 2'd2;
        wr(A_CTRL, 32'd9);
        wait_done();
        rd_chk("R5 permanent", A_STAT, 32'h4000_0002);
        stub_res = 2'd0;

        // R8 abort with zero
        stub_lat = 1000;
        wr(A_CTRL, 32'd7);
        rd_chk("R8 running before abort", A_STAT, 32'h8000_0000);
        wr(A_CTRL, 32'd0);
        push("R8 cancel pulse", {31'd0, be_cancel}, 32'd1);
        push("R8 start dropped", {31'd0, be_start}, 32'd0);
        rd_chk("R8 aborted status", A_STAT, 32'h4000_0003);
        rd_chk("R12 aborted control", A_CTRL, 32'd7);
        @(negedge clk);
        push("R8 cancel one cycle", {31'd0, be_cancel}, 32'd0);
        wr(A_CTRL, 32'd0);
        rd_chk("R8 idle abort", A_STAT, 32'h4000_0003);

        // R9 abort by a new number
        wr(A_CTRL, 32'd8);
        wr(A_CTRL, 32'd12);
        rd_chk("R9 aborted first", A_STAT, 32'h4000_0003);
        push("R9 cancel", {31'd0, be_cancel}, 32'd1);
        rd_chk("R9 control still old", A_CTRL, 32'd8);
        @(negedge clk);
        rd_chk("R9 new running", A_STAT, 32'h8000_0000);
        push("R9 new start", {31'd0, be_start}, 32'd1);
        push("R9 new proc", {28'd0, be_proc}, 32'd12);
        rd_chk("R9 new control", A_CTRL, 32'd12);
        stub_lat = 3;
        wait_done();
        rd_chk("R9 new completes", A_STAT, 32'h4000_0000);

        // R11 writes to other dwords ignored
        wr(A_HDR, 32'hFFFF_FFFF);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_LINK, 32'hFFFF_FFFF);
        rd_chk("R11 header kept", A_HDR, {8'h00, 8'h10, NEXT_PTR, 8'h09});
        rd_chk("R11 status kept", A_STAT, 32'h4000_0000);
        rd_chk("R11 link kept", A_LINK, 32'd5);
        rd_chk("R11 control kept", A_CTRL, 32'd12);
        push("R11 no start", {31'd0, be_start}, 32'd0);

        // R10 one-time calibration
        wr(A_CTRL, 32'd5);
        push("R10 first zcal starts", {31'd0, be_start}, 32'd1);
        wait_done();
        rd_chk("R10 first zcal ok", A_STAT, 32'h4000_0000);
        wr(A_CTRL, 32'd5);
        rd_chk("R10 repeat completes", A_STAT, 32'h4000_0000);
        push("R10 repeat no start", {31'd0, be_start}, 32'd0);
        repeat (3) @(negedge clk);
        push("R10 one backend run", zcal_runs, 32'd1);
        do_reset();
        wr(A_CTRL, 32'd5);
        push("R10 re-armed by reset", {31'd0, be_start}, 32'd1);
        repeat (2) @(negedge clk);
        push("R10 second run after reset", zcal_runs, 32'd2);
        wait_done();

        repeat (3) @(negedge clk);
        summary();
    end

endmodule